// File: doc/BRIEF.md
# Polyphase Interpolate-by-Five Filter

This block raises the sample rate of a signed 16-bit stream by a factor of five. It behaves as though four zero samples were placed after every input sample and the stuffed stream were passed through a 30-tap symmetric low-pass filter with cutoff at one fifth of the Nyquist band. It never forms the stuffed stream. A cyclic phase counter picks one of five six-tap coefficient subsets, and that subset is applied to the six most recent real input samples. Each accepted input therefore costs five short dot products instead of five 30-tap convolutions over mostly zero data.

Upstream hands samples in through a valid/ready pair. Once a sample is taken, the block emits five output samples through a second valid/ready pair, for phases 0 to 4 in that order. The output side honours backpressure: while the sink holds ready low, the pending output and the phase counter both stay where they are. The block takes no new input until the fifth output of the current sample has been handed off. That handoff and the next input acceptance can share one clock cycle, so a stream with no stalls runs at one input every six cycles.

Top module: `interp5_poly`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0, `inReady` is 1, and the history of past inputs reads as all zeros.
- R2: Every input accepted (`inValid` and `inReady` both high at a clock edge) produces exactly five output transfers, and no output is offered while no accepted input is still owed outputs.
- R3: The k-th output transfer after reset (k counted from 0) equals sat16(floor((5·y[k] + 16384) / 32768)). Here y[k] = Σ h[t]·v[k−t] for t = 0..29. The stuffed sequence v[i] is input number i/5 when i is a multiple of 5 and 0 otherwise, and samples before reset count as zero. The taps are Q15 integers, symmetric with h[t] = h[29−t], and for t = 0..14 they are 206, −482, −33, −92, 341, 701, 636, −10, −983, −1632, −1222, 603, 3519, 6537, 8451.
- R4: `inReady` drops in the cycle after an input is accepted and stays low until the fifth output of that input is transferred. Inputs presented while `inReady` is low are not taken and have no effect on any later output.
- R5: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` holds its value on the following cycle.
- R6: Results above 32767 are output as 32767, and results below −32768 are output as −32768.
- R7: In a cycle where the fifth output is transferred and `inValid` is high, `inReady` is already high and the new input is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Upstream offers a sample |
| inReady | output | 1 | Block will take the offered sample at this edge |
| inData | input | 16 | Input sample, signed two's complement |
| outValid | output | 1 | Output sample is present |
| outReady | input | 1 | Sink takes the output sample at this edge |
| outData | output | 16 | Interpolated sample, signed two's complement |

## Verification
Two events can land in the same cycle: the sink taking the last of the five outputs, and the source handing over the next sample. Holding `inValid` and `outReady` high for long stretches creates that overlap on every sample. Random patterns on `outReady` also push it to the cycles where a stall releases. A behavioural model runs alongside the block. It tracks how many outputs are still owed, predicts `inReady` each cycle from that count and the live output handshake, and compares each transferred output against a direct zero-stuffed 30-tap convolution. A lost overlap, or an input taken one cycle too early, shows up either as a wrong `inReady` or as a misaligned output value.

// File: rtl/interp5_pkg.sv
`timescale 1ns/1ps
package interp5_pkg;

  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 15;
  localparam int PHASE_W   = 4;

  typedef logic signed [COEF_W-1:0] coef_t;

  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic               shiftHist;
    logic               loadOut;
    logic [PHASE_W-1:0] phase;
  } strobe_t;

  // Q15 prototype, outermost tap first, centre last
  function automatic coef_t protoCoef(input int idx);
    case (idx)
      0:  return 16'sd206;
      1:  return -16'sd482;
      2:  return -16'sd33;
      3:  return -16'sd92;
      4:  return 16'sd341;
      5:  return 16'sd701;
      6:  return 16'sd636;
      7:  return -16'sd10;
      8:  return -16'sd983;
      9:  return -16'sd1632;
      10: return -16'sd1222;
      11: return 16'sd603;
      12: return 16'sd3519;
      13: return 16'sd6537;
      14: return 16'sd8451;
      default: return '0;
    endcase
  endfunction

  // full symmetric tap set built from the half prototype
  function automatic coef_t tapCoef(input int k, input int taps);
    int mirror;
    mirror = (k < taps / 2) ? k : taps - 1 - k;
    return protoCoef(mirror);
  endfunction

endpackage

// File: rtl/interp5_ctrl.sv
`timescale 1ns/1ps
module interp5_ctrl
  import interp5_pkg::*;
#(
  parameter int FACTOR = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strb
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(FACTOR - 1);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t             state;
  logic [PHASE_W-1:0] phase;
  logic               slotFree;
  logic               accept;
  logic               lastPhase;

  assign slotFree  = !outValid || outReady;
  assign inReady   = (state == ST_IDLE) && slotFree;
  assign accept    = inReady && inValid;
  assign lastPhase = (phase == LAST_PHASE);

  assign strb.shiftHist = accept;
  assign strb.loadOut   = (state == ST_RUN) && slotFree;
  assign strb.phase     = phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      outValid <= 1'b0;
    end else begin
      if (accept) begin
        state <= ST_RUN;
        phase <= '0;
      end else if (strb.loadOut) begin
        phase <= lastPhase ? '0 : phase + 1'b1;
        if (lastPhase) state <= ST_IDLE;
      end
      if (strb.loadOut)  outValid <= 1'b1;
      else if (outReady) outValid <= 1'b0;
    end
  end

  // R4
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (state == ST_RUN) && (phase == '0));

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PHASE);

  // R2
  wrap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadOut && lastPhase) |=> (state == ST_IDLE));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(phase));

endmodule

// File: rtl/interp5_datapath.sv
`timescale 1ns/1ps
module interp5_datapath
  import interp5_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FACTOR = 5,
  parameter int TAPS   = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] inData,
  input  strobe_t                  strb,
  output logic signed [DATA_W-1:0] outData
);

  localparam int BRANCH  = TAPS / FACTOR;
  localparam int PROD_W  = DATA_W + COEF_W;
  localparam int SUM_W   = PROD_W + $clog2(BRANCH) + 1;
  localparam int SCALE_W = SUM_W + $clog2(FACTOR) + 1;

  localparam logic signed [SCALE_W-1:0] FACTOR_S   = SCALE_W'(FACTOR);
  localparam logic signed [SCALE_W-1:0] ROUND_BIAS = SCALE_W'(1) <<< (COEF_FRAC - 1);
  localparam logic signed [SCALE_W-1:0] OUT_MAX    = (SCALE_W'(1) <<< (DATA_W - 1)) - SCALE_W'(1);
  localparam logic signed [SCALE_W-1:0] OUT_MIN    = -(SCALE_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0]  hist    [BRANCH];
  coef_t                     coefSel [BRANCH];
  logic signed [PROD_W-1:0]  prod    [BRANCH];
  logic signed [SUM_W-1:0]   sumAcc;
  logic signed [SCALE_W-1:0] scaled;
  logic signed [SCALE_W-1:0] rounded;
  logic signed [DATA_W-1:0]  satVal;

  // low-rate input history, newest in slot 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < BRANCH; j++) hist[j] <= '0;
    end else if (strb.shiftHist) begin
      hist[0] <= inData;
      for (int j = 1; j < BRANCH; j++) hist[j] <= hist[j-1];
    end
  end

  // phase p applies taps p, p+FACTOR, p+2*FACTOR ... to the history
  always_comb begin
    for (int j = 0; j < BRANCH; j++) begin
      coefSel[j] = tapCoef(int'(strb.phase) + FACTOR * j, TAPS);
      prod[j]    = PROD_W'(hist[j]) * PROD_W'(coefSel[j]);
    end
  end

  always_comb begin
    sumAcc = '0;
    for (int j = 0; j < BRANCH; j++) sumAcc = sumAcc + SUM_W'(prod[j]);
    scaled  = SCALE_W'(sumAcc) * FACTOR_S;
    rounded = (scaled + ROUND_BIAS) >>> COEF_FRAC;
    if (rounded > OUT_MAX)      satVal = OUT_MAX[DATA_W-1:0];
    else if (rounded < OUT_MIN) satVal = OUT_MIN[DATA_W-1:0];
    else                        satVal = rounded[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outData <= '0;
    else if (strb.loadOut) outData <= satVal;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftHist && strb.loadOut));

endmodule

// File: rtl/interp5_poly.sv
`timescale 1ns/1ps
module interp5_poly
  import interp5_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FACTOR = 5,
  parameter int TAPS   = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] outData
);

  strobe_t strb;

  interp5_ctrl #(.FACTOR(FACTOR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strb     (strb)
  );

  interp5_datapath #(.DATA_W(DATA_W), .FACTOR(FACTOR), .TAPS(TAPS)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strb    (strb),
    .outData (outData)
  );

endmodule

// File: tb/interp5_poly_bench.sv
`timescale 1ns/1ps
module interp5_poly_bench;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               outReady = 1'b0;
  logic signed [15:0] inData = '0;
  logic               inReady;
  logic               outValid;
  logic signed [15:0] outData;

  always #5 clk = ~clk;

  interp5_poly u_interp5_poly (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .inData   (inData),
    .outValid (outValid),
    .outReady (outReady),
    .outData  (outData)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  longint vq[$];
  longint expq[$];
  int     pending = 0;
  bit     prevStall = 0;
  logic signed [15:0] prevData = '0;
  logic [31:0] rng = 32'h1234abcd;

  int protoTab[15] = '{206, -482, -33, -92, 341, 701, 636, -10,
                       -983, -1632, -1222, 603, 3519, 6537, 8451};

  function automatic logic [31:0] nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint fullTap(input int k);
    return longint'(protoTab[(k < 15) ? k : 29 - k]);
  endfunction

  // zero-stuffed direct convolution over all 30 taps
  function automatic longint refOut(input int m);
    longint acc = 0;
    longint t;
    for (int k = 0; k < 30; k++) begin
      if (m - k >= 0) acc += fullTap(k) * vq[m-k];
    end
    t = (acc * 5 + 16384) >>> 15;
    if (t > 32767)  t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic step(input bit iv, input longint d, input bit ordy);
    bit     expReady;
    int     base;
    longint e;
    @(negedge clk);
    if (prevStall) begin
      check(outValid == 1'b1, "R5 valid held", longint'(outValid), 1);
      check(outData == prevData, "R5 data held", longint'(outData), longint'(prevData));
    end
    if (pending == 0)
      check(outValid == 1'b0, "R2 no spurious output", longint'(outValid), 0);
    inValid  = iv;
    inData   = 16'(d);
    outReady = ordy;
    #1;
    expReady = (pending == 0) || (pending == 1 && outValid && outReady);
    if (pending == 1 && outValid && outReady && inValid)
      check(inReady == expReady, "R7 overlap accept", longint'(inReady), longint'(expReady));
    else
      check(inReady == expReady, "R4 ready", longint'(inReady), longint'(expReady));
    if (outValid && outReady) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 extra output", 1, 0);
      end else begin
        e = expq.pop_front();
        if (e == 32767 || e == -32768)
          check(longint'(outData) == e, "R6 saturated value", longint'(outData), e);
        else
          check(longint'(outData) == e, "R3 output value", longint'(outData), e);
        pending--;
      end
    end
    if (inValid && inReady) begin
      base = vq.size();
      vq.push_back(longint'(inData));
      for (int z = 0; z < 4; z++) vq.push_back(0);
      for (int p = 0; p < 5; p++) expq.push_back(refOut(base + p));
      pending += 5;
    end
    prevStall = outValid && !outReady;
    prevData  = outData;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    longint      d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid in reset", longint'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady in reset", longint'(inReady), 1);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1 outValid after reset", longint'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", longint'(inReady), 1);

    // R1 history zero: first impulse response must show no earlier data
    step(1, 16384, 1);
    for (int i = 0; i < 80; i++) step(i % 7 == 0, 0, 1);

    for (int mode = 0; mode < 6; mode++) begin
      for (int i = 0; i < 300; i++) begin
        r = nextRand();
        case (mode)
          0: begin d = longint'($signed(r[15:0])); step(1, d, 1); end          // R7 back to back
          1: begin d = longint'($signed(r[31:16])); step(r[3], d, r[7] | r[9]); end // R5 stalls
          2: step(1, 32767, r[5] | r[6]);                                       // R6 positive
          3: step(1, -32768, r[5] | r[6]);                                      // R6 negative
          4: step(r[2] | r[4], r[11] ? 32767 : -32768, r[8]);                   // R4 ignored inputs
          default: step(r[1], (i % 40 == 0) ? -20000 : 0, r[0] | r[10]);        // R3 impulses
        endcase
      end
    end

    for (int i = 0; i < 40; i++) step(0, 0, 1);
    check(pending == 0, "R2 all outputs delivered", pending, 0);
    check(outValid == 1'b0, "R2 idle after flush", longint'(outValid), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule